// File: doc/BRIEF.md
# Microsecond Timer and Wait Unit

This block gives a packet-processing engine its timing services through a small bank of 16-bit registers on a simple request/ready bus. A prescaler turns the system clock into a one-cycle microsecond tick. The tick drives a free-running timestamp that any requester can read. The bank also holds a programmable busy-wait, a set of wait-for-event registers that share one timeout, and a handful of scratch words.

Waiting works by holding back the bus handshake. A write to the delay register keeps `ready` low for the written number of microseconds. An access to a wait-for-event register keeps `ready` low until the chosen external pulse input shows a rising edge, or until the shared timeout runs out. A read of a wait-for-event register returns how many microsecond ticks passed during the wait. A timeout sets an error flag, and that flag stays set until the next event wait starts. Event inputs pass through two-flop synchronisers. An edge only counts if the pin rose after the access was accepted.

Top module: `usec_wait_unit`

## Requirements
- R1: One microsecond tick occurs every TPU = CLK_HZ/1e6 clocks; the first tick falls on the TPU-th rising edge after reset is released. A read of byte offset 0x0 returns the number of ticks seen before the accepting edge, modulo 2^16.
- R2: A write to offset 0x0 completes without stalling and leaves the timestamp unchanged.
- R3: A write of N to offset 0x2 holds `ready` low until the N-th tick after the accepting edge, and `ready` rises on that tick's edge. N = 0 completes like a plain access.
- R4: A read of offset 0x2 does not stall and returns the last value written there (0 after reset).
- R5: Offset 0x4 is a read/write timeout in microseconds, shared by all event waits. Accesses to it do not stall.
- R6: Offsets 0x6, 0x8, 0xA and 0xC wait for a rising edge on `evt_in[0]`, `evt_in[1]`, `evt_in[2]` and `evt_in[3]`. Offset 0xE waits for a rising edge on any of the inputs. Both reads and writes wait. Write data is discarded and changes no register. An edge on an input that was not selected does not end the wait.
- R7: Each input passes through a two-flop synchroniser and an edge detector. A pin that rises just before clock edge `a` is seen at edge `a+2`. Only a pin change that comes after the accepting edge `s` can end the wait. Rises that the detector reports at edges `s+1` and `s+2` are ignored.
- R8: An event wait that ends on an edge returns, in `rdata`, the count of ticks that fell strictly between the accepting edge and the completing edge.
- R9: With a timeout T other than 0, an event wait with no qualifying edge ends on the T-th tick after acceptance. It returns T and sets `tmo_err`. T = 0 means the wait never times out.
- R10: `tmo_err` clears on the edge that accepts an event wait, and a wait that ends on an edge leaves it clear. If a qualifying edge and the timeout tick land on the same clock, the edge wins.
- R11: Even offsets 0x10 to 0x1E are eight independent read/write scratch words.
- R12: `ready` is a one-cycle pulse that rises on the edge after acceptance for non-waiting accesses. The request must be held until `ready`, and `req` is ignored on the cycle after `ready`. Odd byte addresses read 0, do not stall and write nothing. During reset `ready`, `rdata` and `tmo_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | N_EVT | Asynchronous external event/reference pulses |
| req | input | 1 | Access request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid while ready is high |
| ready | output | 1 | One-cycle access-complete pulse |
| tmo_err | output | 1 | Last event wait ended by timeout |

## Verification
The timestamp and the busy-wait are checked from several start phases relative to the tick, including zero, one and several microseconds, so that an off-by-one in the counting of ticks can be seen. Each event input is tried with edges at different distances after acceptance: the nearest edge that may count, a pin that rises on the accepting cycle (which must be ignored), a pulse on an input that was not selected, and the any-input register. The timeout is tried with a normal value, with 0 (never times out), and with an edge placed exactly on the timeout tick, which tells the edge-wins priority apart from the reverse. After event writes, the other registers are read back to show that the write data was discarded.

// File: rtl/usec_wait_pkg.sv
package usec_wait_pkg;

    typedef enum logic [2:0] {K_STAMP, K_DELAY, K_TMO, K_EVT, K_SCR, K_NONE} kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [3:0] sel;
    } dec_t;

    typedef enum logic [1:0] {ST_IDLE, ST_DLY, ST_EVT, ST_RESP} st_e;

    localparam int WORD_STAMP = 0;
    localparam int WORD_DELAY = 1;
    localparam int WORD_TMO   = 2;
    localparam int WORD_EVT0  = 3;
    localparam int WORD_SCR0  = 8;

    // Byte offset to register class; event slot n_evt is the any-input slot.
    function automatic dec_t decode_word(input int a, input int n_evt, input int n_scr);
        dec_t d;
        int   w;
        d.kind = K_NONE;
        d.sel  = '0;
        w      = a / 2;
        if (a % 2 != 0)                                d.kind = K_NONE;
        else if (w == WORD_STAMP)                      d.kind = K_STAMP;
        else if (w == WORD_DELAY)                      d.kind = K_DELAY;
        else if (w == WORD_TMO)                        d.kind = K_TMO;
        else if (w >= WORD_EVT0 && w <= WORD_EVT0 + n_evt) begin
            d.kind = K_EVT;
            d.sel  = 4'(w - WORD_EVT0);
        end
        else if (w >= WORD_SCR0 && w < WORD_SCR0 + n_scr) begin
            d.kind = K_SCR;
            d.sel  = 4'(w - WORD_SCR0);
        end
        return d;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int TPU = 50,
    parameter int DW  = 16
) (
    input  logic          clk,
    input  logic          rst,
    output logic          tick,
    output logic [DW-1:0] stamp
);
    localparam int PW = (TPU > 1) ? $clog2(TPU) : 1;

    logic [PW-1:0] pc;

    assign tick = (pc == PW'(TPU - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            stamp <= '0;
        end else begin
            pc <= tick ? '0 : pc + PW'(1);
            if (tick) stamp <= stamp + DW'(1);
        end
    end

    assert_stamp_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(stamp));

    assert_stamp_step_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> stamp == $past(stamp) + DW'(1));

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        logic s1, s2, prev;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1   <= 1'b0;
                s2   <= 1'b0;
                prev <= 1'b0;
            end else begin
                s1   <= pin[g];
                s2   <= s1;
                prev <= s2;
            end
        end
        assign rise[g] = s2 & ~prev;

        assert_rise_single_R7: assert property (@(posedge clk) disable iff (rst)
            rise[g] |=> !rise[g]);
    end

endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
    import usec_wait_pkg::*;
#(
    parameter int DW    = 16,
    parameter int N_SCR = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  dec_t          dec,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] stamp,
    output logic [DW-1:0] rd_val,
    output logic [DW-1:0] tmo
);
    logic [DW-1:0] dly_q;
    logic [DW-1:0] tmo_q;
    logic [DW-1:0] scr_q [N_SCR];

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= '0;
            tmo_q <= '0;
        end else if (wr_en) begin
            if (dec.kind == K_DELAY) dly_q <= wdata;
            if (dec.kind == K_TMO)   tmo_q <= wdata;
        end
    end

    for (genvar g = 0; g < N_SCR; g++) begin : g_scr
        always_ff @(posedge clk) begin
            if (rst)
                scr_q[g] <= '0;
            else if (wr_en && dec.kind == K_SCR && dec.sel == 4'(g))
                scr_q[g] <= wdata;
        end
    end

    always_comb begin
        rd_val = '0;
        case (dec.kind)
            K_STAMP: rd_val = stamp;
            K_DELAY: rd_val = dly_q;
            K_TMO:   rd_val = tmo_q;
            K_SCR: begin
                for (int i = 0; i < N_SCR; i++)
                    if (dec.sel == 4'(i)) rd_val = scr_q[i];
            end
            default: rd_val = '0;
        endcase
    end

    assign tmo = tmo_q;

    assert_tmo_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && dec.kind == K_TMO) |=> $stable(tmo_q));

endmodule

// File: rtl/usec_wait_unit.sv
module usec_wait_unit
    import usec_wait_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int DW     = 16,
    parameter int N_EVT  = 4,
    parameter int N_SCR  = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EVT-1:0]  evt_in,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              ready,
    output logic              tmo_err
);
    localparam int TPU = CLK_HZ / 1_000_000;

    logic             tick;
    logic [DW-1:0]    stamp;
    logic [N_EVT-1:0] rise;
    logic [DW-1:0]    rd_val;
    logic [DW-1:0]    tmo;
    dec_t             dec;
    logic             wr_en;

    st_e              st;
    logic [DW-1:0]    remain;
    logic [DW-1:0]    elapsed;
    logic [1:0]       arm;
    logic [3:0]       evt_sel;
    logic             sel_rise;
    logic             hit;

    tmr_prescale #(.TPU(TPU), .DW(DW)) u_pre (
        .clk(clk), .rst(rst), .tick(tick), .stamp(stamp));

    tmr_edge_sync #(.N(N_EVT)) u_sync (
        .clk(clk), .rst(rst), .pin(evt_in), .rise(rise));

    assign dec   = decode_word(int'(addr), N_EVT, N_SCR);
    assign wr_en = (st == ST_IDLE) && req && we;

    tmr_regbank #(.DW(DW), .N_SCR(N_SCR)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .dec(dec), .wdata(wdata),
        .stamp(stamp), .rd_val(rd_val), .tmo(tmo));

    always_comb begin
        sel_rise = 1'b0;
        for (int i = 0; i < N_EVT; i++)
            if (evt_sel == 4'(i)) sel_rise = rise[i];
        if (evt_sel == 4'(N_EVT)) sel_rise = |rise;
    end

    assign hit = (arm == 2'd0) && sel_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ready   <= 1'b0;
            rdata   <= '0;
            tmo_err <= 1'b0;
            remain  <= '0;
            elapsed <= '0;
            arm     <= '0;
            evt_sel <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req) begin
                        if (dec.kind == K_DELAY && we && wdata != '0) begin
                            st     <= ST_DLY;
                            remain <= wdata;
                        end else if (dec.kind == K_EVT) begin
                            st      <= ST_EVT;
                            elapsed <= '0;
                            arm     <= 2'd2;
                            evt_sel <= dec.sel;
                            tmo_err <= 1'b0;
                        end else begin
                            st    <= ST_RESP;
                            ready <= 1'b1;
                            rdata <= we ? '0 : rd_val;
                        end
                    end
                end
                ST_DLY: begin
                    if (tick) begin
                        remain <= remain - DW'(1);
                        if (remain == DW'(1)) begin
                            st    <= ST_RESP;
                            ready <= 1'b1;
                            rdata <= '0;
                        end
                    end
                end
                ST_EVT: begin
                    if (arm != 2'd0) arm <= arm - 2'd1;
                    if (hit) begin
                        st    <= ST_RESP;
                        ready <= 1'b1;
                        rdata <= elapsed;
                    end else if (tick) begin
                        elapsed <= elapsed + DW'(1);
                        if (tmo != '0 && elapsed + DW'(1) == tmo) begin
                            st      <= ST_RESP;
                            ready   <= 1'b1;
                            rdata   <= tmo;
                            tmo_err <= 1'b1;
                        end
                    end
                end
                default: begin
                    ready <= 1'b0;
                    st    <= ST_IDLE;
                end
            endcase
        end
    end

    assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    assert_dly_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DLY) && !tick |=> !ready);

    assert_evt_blank_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EVT) && (arm != 2'd0) && !tick |=> !ready);

    assert_err_on_done_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_err) |-> ready);

    assert_err_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) && req && (dec.kind == K_EVT) |=> !tmo_err);

endmodule

// File: tb/usec_wait_unit_tb.sv
module usec_wait_unit_tb_top;

    localparam int TPU = 50;
    localparam int INF = 1 << 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  evt = '0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ready;
    logic        tmo_err;

    int          ecount = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          pend = 1'b0;
    int          exp_d = 0;
    logic [15:0] exp_rd = '0;
    bit          exp_chk = 1'b0;
    string       exp_tag = "R12";
    logic [15:0] scr_m [8];

    usec_wait_unit dut_i (
        .clk(clk), .rst(rst), .evt_in(evt), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready), .tmo_err(tmo_err));

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) ecount <= 0;
        else     ecount <= ecount + 1;
    end

    // Reference model check on every clock: ready pulse and read data
    always @(negedge clk) begin
        bit want;
        if (!rst) begin
            want = pend && (ecount - 1 == exp_d);
            n_vec++;
            if (ready !== want) begin
                n_bad++;
                $display("FAIL %s ready act=%0b exp=%0b edge=%0d", exp_tag, ready, want, ecount - 1);
            end
            if (want && exp_chk) begin
                n_vec++;
                if (rdata !== exp_rd) begin
                    n_bad++;
                    $display("FAIL %s rdata act=%h exp=%h", exp_tag, rdata, exp_rd);
                end
            end
            if (want) pend = 1'b0;
        end
    end

    function automatic int tk_upto(input int x);
        return (x + 1) / TPU;
    endfunction

    function automatic int nth_tick(input int s, input int n);
        return ((s + 1) / TPU) * TPU + TPU - 1 + (n - 1) * TPU;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic bus_op(input bit w, input int a, input logic [15:0] wd, input int d,
                          input logic [15:0] rd, input bit chk, input string tag);
        int guard;
        exp_d = d; exp_rd = rd; exp_chk = chk; exp_tag = tag; pend = 1'b1;
        req = 1'b1; we = w; addr = 5'(a); wdata = wd;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (ready !== 1'b1 && guard < 20000);
        req = 1'b0; we = 1'b0;
        if (guard >= 20000) begin
            n_bad++;
            $display("FAIL %s ready act=0 exp=1 (never completed)", tag);
            pend = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic rd(input int a, input logic [15:0] e, input string tag);
        bus_op(1'b0, a, 16'h0, ecount, e, 1'b1, tag);
    endtask

    task automatic wr(input int a, input logic [15:0] d, input string tag);
        bus_op(1'b1, a, d, ecount, 16'h0, 1'b0, tag);
    endtask

    task automatic rd_stamp(input string tag);
        rd(0, 16'(ecount / TPU), tag);
    endtask

    task automatic wr_delay(input int n);
        int s;
        s = ecount;
        bus_op(1'b1, 2, 16'(n), (n == 0) ? s : nth_tick(s, n), 16'h0, 1'b0, "R3");
    endtask

    // ofs: pin changes before edge s+ofs; -1 = no pulse; -2 = land on timeout tick
    task automatic evt_op(input int a, input bit w, input int pin, input bit counts,
                          input int ofs_in, input int tmo, input string tag);
        int s, r, t, d, ofs;
        bit e_err;
        logic [15:0] e_rd;
        s = ecount;
        ofs = ofs_in;
        t = (tmo != 0) ? nth_tick(s, tmo) : INF;
        if (ofs == -2) ofs = t - s - 2;
        r = (counts && ofs >= 1) ? s + ofs + 2 : INF;
        if (r <= t) begin
            d = r; e_rd = 16'(tk_upto(r - 1) - tk_upto(s)); e_err = 1'b0;
        end else begin
            d = t; e_rd = 16'(tmo); e_err = 1'b1;
        end
        fork
            bus_op(w, a, 16'hBEEF, d, e_rd, !w, tag);
            begin
                if (pin >= 0 && ofs == 0) evt[pin] = 1'b1;
                @(negedge clk);
                n_vec++;
                if (tmo_err !== 1'b0) begin
                    n_bad++;
                    $display("FAIL R10 err after accept act=%0b exp=0", tmo_err);
                end
                if (pin >= 0 && ofs > 0) begin
                    while (ecount < s + ofs) @(negedge clk);
                    evt[pin] = 1'b1;
                end
                if (pin >= 0) begin
                    repeat (4) @(negedge clk);
                    evt[pin] = 1'b0;
                end
            end
        join
        repeat (4) @(negedge clk);
        n_vec++;
        if (tmo_err !== e_err) begin
            n_bad++;
            $display("FAIL %s tmo_err act=%0b exp=%0b", tag, tmo_err, e_err);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        n_vec++;
        if (ready !== 1'b0 || rdata !== 16'h0 || tmo_err !== 1'b0) begin
            n_bad++;
            $display("FAIL R12 reset act=%0b/%h/%0b exp=0/0000/0", ready, rdata, tmo_err);
        end
        rst = 1'b0;

        // R1 timestamp from several phases
        rd_stamp("R1");
        repeat (73) @(negedge clk);
        rd_stamp("R1");
        repeat (130) @(negedge clk);
        rd_stamp("R1");

        // R2 writes to the timestamp are discarded
        wr(0, 16'hFFFF, "R2");
        rd_stamp("R2");

        // R3 / R4 busy-wait and its readback
        rd(2, 16'h0, "R4");
        wr_delay(0);
        rd(2, 16'h0, "R4");
        wr_delay(3);
        rd(2, 16'h3, "R4");
        repeat (17) @(negedge clk);
        wr_delay(1);
        rd(2, 16'h1, "R4");
        rd_stamp("R1");

        // R5 timeout register
        wr(4, 16'd40, "R5");
        rd(4, 16'd40, "R5");

        // R11 scratch words
        for (int i = 0; i < 8; i++) begin
            scr_m[i] = 16'(16'h1357 * (i + 3)) ^ 16'hA5C3;
            wr(16 + 2 * i, scr_m[i], "R11");
        end
        for (int i = 7; i >= 0; i--) rd(16 + 2 * i, scr_m[i], "R11");

        // R12 odd addresses
        rd(17, 16'h0, "R12");
        wr(19, 16'h7777, "R12");
        rd(18, scr_m[1], "R12");

        // R6 / R8 each input
        evt_op(6, 1'b0, 0, 1'b1, 30, 40, "R8");
        evt_op(8, 1'b1, 1, 1'b1, 120, 40, "R6");
        rd(4, 16'd40, "R6");
        rd(2, 16'h1, "R6");
        rd(16, scr_m[0], "R6");
        evt_op(10, 1'b0, 2, 1'b1, 75, 40, "R8");
        evt_op(12, 1'b0, 3, 1'b1, 1, 40, "R7");
        evt_op(14, 1'b0, 2, 1'b1, 60, 40, "R6");

        // R6 / R9 pulse on a pin that was not selected
        wr(4, 16'd3, "R5");
        evt_op(8, 1'b0, 0, 1'b0, 20, 3, "R9");
        // R7 pin rising on the accepting cycle is ignored
        evt_op(6, 1'b0, 0, 1'b1, 0, 3, "R7");
        // R10 flag cleared by the next wait, which ends on an edge
        evt_op(6, 1'b0, 0, 1'b1, 10, 3, "R10");
        // R10 edge on the same clock as the timeout tick wins
        wr(4, 16'd2, "R5");
        evt_op(12, 1'b0, 3, 1'b1, -2, 2, "R10");
        // R9 timeout 0 never expires
        wr(4, 16'd0, "R5");
        evt_op(6, 1'b0, 0, 1'b1, 400, 0, "R9");
        rd_stamp("R1");

        summary();
        $finish;
    end

endmodule